// File: doc/BRIEF.md
# Cascaded Interrupt Priority Resolver

This block is the request-and-acknowledge core of two chained 8-input interrupt controllers, giving 16 request lines. Lines 0 to 7 belong to the primary controller and lines 8 to 15 to the secondary. The secondary feeds into line 2 of the primary. Each controller holds a request register, an in-service register, an asserted flag and a rotating lowest-priority pointer. Both mask registers and both vector bases come in as inputs from the surrounding command logic. The pointers are loaded through a small write strobe.

Request lines are raised and dropped with single-cycle assert and deassert pulses. A combinational pending output tells the processor side that an unmasked request is waiting. When the processor acknowledges, the block searches the primary first and then the secondary. Each search starts just above that controller's lowest-priority pointer and wraps around. The block then updates the request and in-service bits of both controllers together and returns a 16-bit vector one clock later. If nothing can be granted, it returns the all-ones value. End-of-interrupt handling is done elsewhere, so in-service bits here are only ever set.

Top module: `irq_cascade_resolver`

## Requirements
- R1: After reset, all request bits, in-service bits and asserted flags are zero, pending and ackValid are low, and both lowest-priority pointers hold 7, so line 0 of each controller has the highest priority.
- R2: An assertPulse with assertLine 0..7 sets that bit of priReq. An assertPulse with assertLine 8..15 sets bit (assertLine-8) of secReq. An assert whose line is masked (priMask or secMask bit set) changes nothing.
- R3: An accepted assert of a secondary line also sets priReq bit 2. A deassertPulse clears the addressed request bit. A secondary deassert that leaves secReq empty also clears priReq bit 2, and one that leaves secReq non-empty leaves priReq bit 2 alone.
- R4: pending is high exactly when (priReq AND NOT (priMask OR 8'h04)) or (secReq AND NOT secMask) is nonzero, both evaluated on the current state and masks.
- R5: Each search starts at (pointer+1) mod 8 and walks upward through all 8 lines, wrapping from 7 to 0. A ptrLoad writes ptrValue into the secondary pointer when ptrSelSec is 1 and into the primary pointer otherwise. The new pointer is used from the next cycle on.
- R6: The primary is searched first and skips line 2 and masked lines. On a hit, that priReq bit clears, that priIsr bit sets, and the vector is the 16-bit unwrapped sum of the line number and priVecBase.
- R7: With no primary hit, the secondary is searched with its own pointer, skipping masked lines. On a hit, that secReq bit and priReq bit 2 clear, that secIsr bit and priIsr bit 2 set, and the vector is the line number plus secVecBase.
- R8: Each controller's asserted flag sets on any accepted assert to it; a secondary assert sets both flags. A primary grant that empties priReq clears the primary flag. A secondary grant that empties secReq clears the secondary flag, and also the primary flag if priReq is empty. A nonzero request register always has its flag set.
- R9: An acknowledge when neither flag is set, or when no eligible request is found, returns 16'hFFFF and changes no request, in-service or flag state.
- R10: ackValid pulses high for one cycle, in the clock after an ackStrobe, with ackVector valid in that same cycle. Within one cycle the assert is applied first, then the deassert, then the acknowledge search.
- R11: In-service bits are only ever set by grants and are never cleared except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| assertPulse | input | 1 | Raise the request line on assertLine |
| assertLine | input | 4 | Line number 0..15 to raise |
| deassertPulse | input | 1 | Drop the request line on deassertLine |
| deassertLine | input | 4 | Line number 0..15 to drop |
| ackStrobe | input | 1 | Processor acknowledge |
| priMask | input | 8 | Primary mask, bit set blocks the line |
| secMask | input | 8 | Secondary mask, bit set blocks the line |
| priVecBase | input | 8 | Primary vector base |
| secVecBase | input | 8 | Secondary vector base |
| ptrLoad | input | 1 | Load a lowest-priority pointer |
| ptrSelSec | input | 1 | 1 selects the secondary pointer for ptrLoad |
| ptrValue | input | 3 | New pointer value |
| pending | output | 1 | An unmasked request is waiting |
| ackValid | output | 1 | Acknowledge result valid |
| ackVector | output | 16 | Granted vector, or 16'hFFFF |
| priReq | output | 8 | Primary request register |
| secReq | output | 8 | Secondary request register |
| priIsr | output | 8 | Primary in-service register |
| secIsr | output | 8 | Secondary in-service register |

## Verification
Request and in-service changes from an assert, a deassert or a pointer load appear right after the clock edge that samples the pulse. pending follows combinationally from that state. An acknowledge result is due in the cycle after the strobe. The bench drives every input on the falling edge, steps a reference model right after the rising edge, and compares all outputs on the next falling edge, so each result is read in the exact cycle it is due. Directed cases with hand-worked vectors cover the default pointer, pointer rotation, the wrap of the vector sum past 255, same-cycle assert and acknowledge, and the all-ones miss.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int CTRL_LINES   = 8;
  localparam int LINE_W       = $clog2(CTRL_LINES);
  localparam int SEL_W        = LINE_W + 1;
  localparam int CASCADE_LINE = 2;

  typedef logic [CTRL_LINES-1:0] lineVec_t;

  localparam lineVec_t CASCADE_BIT = lineVec_t'(1) << CASCADE_LINE;

  // strobes from control to datapath for one acknowledge
  typedef struct packed {
    logic              grantPri;
    logic              grantSec;
    logic [LINE_W-1:0] line;
  } grantCmd_t;
endpackage

// File: rtl/irq_rotate_search.sv
module irq_rotate_search #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  eligible,
  input  logic [IW-1:0] lowPtr,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] probe;

  // walk upward from the slot just above the lowest-priority pointer
  always_comb begin
    hit   = 1'b0;
    idx   = '0;
    probe = '0;
    for (int k = 0; k < N; k++) begin
      probe = lowPtr + IW'(k + 1);
      if (!hit && eligible[probe]) begin
        hit = 1'b1;
        idx = probe;
      end
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
(
  input  logic              ackStrobe,
  input  lineVec_t          stagedPriReq,
  input  lineVec_t          stagedSecReq,
  input  logic              stagedFlagAny,
  input  lineVec_t          priMask,
  input  lineVec_t          secMask,
  input  logic [LINE_W-1:0] priPtr,
  input  logic [LINE_W-1:0] secPtr,
  output grantCmd_t         cmd
);
  lineVec_t          priElig, secElig;
  logic              priHit, secHit;
  logic [LINE_W-1:0] priIdx, secIdx;

  assign priElig = stagedPriReq & ~(priMask | CASCADE_BIT);
  assign secElig = stagedSecReq & ~secMask;

  irq_rotate_search #(.N(CTRL_LINES), .IW(LINE_W)) u_priSearch (
    .eligible(priElig), .lowPtr(priPtr), .hit(priHit), .idx(priIdx)
  );
  irq_rotate_search #(.N(CTRL_LINES), .IW(LINE_W)) u_secSearch (
    .eligible(secElig), .lowPtr(secPtr), .hit(secHit), .idx(secIdx)
  );

  always_comb begin
    cmd = '0;
    if (ackStrobe && stagedFlagAny) begin
      if (priHit) begin
        cmd.grantPri = 1'b1;
        cmd.line     = priIdx;
      end else if (secHit) begin
        cmd.grantSec = 1'b1;
        cmd.line     = secIdx;
      end
    end
  end
endmodule

// File: rtl/irq_cascade_dp.sv
module irq_cascade_dp
  import irq_cascade_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int RESULT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                assertPulse,
  input  logic [SEL_W-1:0]    assertLine,
  input  logic                deassertPulse,
  input  logic [SEL_W-1:0]    deassertLine,
  input  logic                ackStrobe,
  input  lineVec_t            priMask,
  input  lineVec_t            secMask,
  input  logic [VEC_W-1:0]    priVecBase,
  input  logic [VEC_W-1:0]    secVecBase,
  input  logic                ptrLoad,
  input  logic                ptrSelSec,
  input  logic [LINE_W-1:0]   ptrValue,
  input  grantCmd_t           cmd,
  output lineVec_t            stagedPriReq,
  output lineVec_t            stagedSecReq,
  output logic                stagedFlagAny,
  output logic [LINE_W-1:0]   priPtrQ,
  output logic [LINE_W-1:0]   secPtrQ,
  output logic                pending,
  output logic                ackValid,
  output logic [RESULT_W-1:0] ackVector,
  output lineVec_t            priReqQ,
  output lineVec_t            secReqQ,
  output lineVec_t            priIsrQ,
  output lineVec_t            secIsrQ
);
  localparam logic [LINE_W-1:0]   PTR_RESET = LINE_W'(CTRL_LINES - 1);
  localparam logic [RESULT_W-1:0] NO_GRANT  = '1;

  logic priFlagQ, secFlagQ;
  logic sPriFlag, sSecFlag;
  lineVec_t nPriReq, nSecReq, nPriIsr, nSecIsr;
  logic nPriFlag, nSecFlag;
  logic [RESULT_W-1:0] nVector;
  logic [LINE_W-1:0] aLine, dLine;

  assign aLine = assertLine[LINE_W-1:0];
  assign dLine = deassertLine[LINE_W-1:0];

  // stage 1: line raise, then line drop
  always_comb begin
    stagedPriReq = priReqQ;
    stagedSecReq = secReqQ;
    sPriFlag     = priFlagQ;
    sSecFlag     = secFlagQ;
    if (assertPulse) begin
      if (!assertLine[SEL_W-1]) begin
        if (!priMask[aLine]) begin
          stagedPriReq[aLine] = 1'b1;
          sPriFlag            = 1'b1;
        end
      end else if (!secMask[aLine]) begin
        stagedSecReq[aLine] = 1'b1;
        sSecFlag            = 1'b1;
        stagedPriReq        = stagedPriReq | CASCADE_BIT;
        sPriFlag            = 1'b1;
      end
    end
    if (deassertPulse) begin
      if (!deassertLine[SEL_W-1]) begin
        stagedPriReq[dLine] = 1'b0;
      end else begin
        stagedSecReq[dLine] = 1'b0;
        if (stagedSecReq == '0) stagedPriReq = stagedPriReq & ~CASCADE_BIT;
      end
    end
  end

  assign stagedFlagAny = sPriFlag | sSecFlag;

  // stage 2: apply the grant chosen by control
  always_comb begin
    nPriReq  = stagedPriReq;
    nSecReq  = stagedSecReq;
    nPriIsr  = priIsrQ;
    nSecIsr  = secIsrQ;
    nPriFlag = sPriFlag;
    nSecFlag = sSecFlag;
    nVector  = NO_GRANT;
    if (cmd.grantPri) begin
      nPriReq[cmd.line] = 1'b0;
      nPriIsr[cmd.line] = 1'b1;
      if (nPriReq == '0) nPriFlag = 1'b0;
      nVector = RESULT_W'(cmd.line) + RESULT_W'(priVecBase);
    end else if (cmd.grantSec) begin
      nSecReq[cmd.line] = 1'b0;
      nPriReq           = nPriReq & ~CASCADE_BIT;
      nSecIsr[cmd.line] = 1'b1;
      nPriIsr           = nPriIsr | CASCADE_BIT;
      if (nSecReq == '0) begin
        nSecFlag = 1'b0;
        if (nPriReq == '0) nPriFlag = 1'b0;
      end
      nVector = RESULT_W'(cmd.line) + RESULT_W'(secVecBase);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      priReqQ   <= '0;
      secReqQ   <= '0;
      priIsrQ   <= '0;
      secIsrQ   <= '0;
      priFlagQ  <= 1'b0;
      secFlagQ  <= 1'b0;
      priPtrQ   <= PTR_RESET;
      secPtrQ   <= PTR_RESET;
      ackValid  <= 1'b0;
      ackVector <= NO_GRANT;
    end else begin
      priReqQ   <= nPriReq;
      secReqQ   <= nSecReq;
      priIsrQ   <= nPriIsr;
      secIsrQ   <= nSecIsr;
      priFlagQ  <= nPriFlag;
      secFlagQ  <= nSecFlag;
      ackValid  <= ackStrobe;
      ackVector <= nVector;
      if (ptrLoad) begin
        if (ptrSelSec) secPtrQ <= ptrValue;
        else           priPtrQ <= ptrValue;
      end
    end
  end

  assign pending = |(priReqQ & ~(priMask | CASCADE_BIT)) | |(secReqQ & ~secMask);

  p_isr_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((priIsrQ & $past(priIsrQ)) == $past(priIsrQ)) && ((secIsrQ & $past(secIsrQ)) == $past(secIsrQ)));

  p_one_grant_per_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({priIsrQ ^ $past(priIsrQ), secIsrQ ^ $past(secIsrQ)}) <= 2);

  p_sec_grant_marks_cascade_r7: assert property (@(posedge clk) disable iff (!rstN)
    (secIsrQ != $past(secIsrQ)) |-> priIsrQ[CASCADE_LINE]);

  p_flag_covers_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((priReqQ == '0) || priFlagQ) && ((secReqQ == '0) || secFlagQ));

  p_miss_keeps_isr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && (ackVector == NO_GRANT)) |-> ($stable(priIsrQ) && $stable(secIsrQ)));

  p_valid_follows_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(ackStrobe));
endmodule

// File: rtl/irq_cascade_resolver.sv
module irq_cascade_resolver
  import irq_cascade_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int RESULT_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                assertPulse,
  input  logic [SEL_W-1:0]    assertLine,
  input  logic                deassertPulse,
  input  logic [SEL_W-1:0]    deassertLine,
  input  logic                ackStrobe,
  input  logic [7:0]          priMask,
  input  logic [7:0]          secMask,
  input  logic [VEC_W-1:0]    priVecBase,
  input  logic [VEC_W-1:0]    secVecBase,
  input  logic                ptrLoad,
  input  logic                ptrSelSec,
  input  logic [LINE_W-1:0]   ptrValue,
  output logic                pending,
  output logic                ackValid,
  output logic [RESULT_W-1:0] ackVector,
  output logic [7:0]          priReq,
  output logic [7:0]          secReq,
  output logic [7:0]          priIsr,
  output logic [7:0]          secIsr
);
  grantCmd_t         cmd;
  lineVec_t          stagedPriReq, stagedSecReq;
  logic              stagedFlagAny;
  logic [LINE_W-1:0] priPtr, secPtr;

  irq_cascade_ctrl u_ctrl (
    .ackStrobe(ackStrobe), .stagedPriReq(stagedPriReq), .stagedSecReq(stagedSecReq),
    .stagedFlagAny(stagedFlagAny), .priMask(priMask), .secMask(secMask),
    .priPtr(priPtr), .secPtr(secPtr), .cmd(cmd)
  );

  irq_cascade_dp #(.VEC_W(VEC_W), .RESULT_W(RESULT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .assertPulse(assertPulse), .assertLine(assertLine),
    .deassertPulse(deassertPulse), .deassertLine(deassertLine),
    .ackStrobe(ackStrobe), .priMask(priMask), .secMask(secMask),
    .priVecBase(priVecBase), .secVecBase(secVecBase),
    .ptrLoad(ptrLoad), .ptrSelSec(ptrSelSec), .ptrValue(ptrValue),
    .cmd(cmd), .stagedPriReq(stagedPriReq), .stagedSecReq(stagedSecReq),
    .stagedFlagAny(stagedFlagAny), .priPtrQ(priPtr), .secPtrQ(secPtr),
    .pending(pending), .ackValid(ackValid), .ackVector(ackVector),
    .priReqQ(priReq), .secReqQ(secReq), .priIsrQ(priIsr), .secIsrQ(secIsr)
  );
endmodule

// File: tb/irq_cascade_resolver_tb.sv
module irq_cascade_resolver_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic assertPulse = 0, deassertPulse = 0, ackStrobe = 0, ptrLoad = 0, ptrSelSec = 0;
  logic [3:0] assertLine = 0, deassertLine = 0;
  logic [2:0] ptrValue = 0;
  logic [7:0] priMask = 0, secMask = 0, priVecBase = 8'h20, secVecBase = 8'h70;
  logic pending, ackValid;
  logic [15:0] ackVector;
  logic [7:0] priReq, secReq, priIsr, secIsr;

  irq_cascade_resolver u_dut (
    .clk(clk), .rstN(rstN), .assertPulse(assertPulse), .assertLine(assertLine),
    .deassertPulse(deassertPulse), .deassertLine(deassertLine), .ackStrobe(ackStrobe),
    .priMask(priMask), .secMask(secMask), .priVecBase(priVecBase), .secVecBase(secVecBase),
    .ptrLoad(ptrLoad), .ptrSelSec(ptrSelSec), .ptrValue(ptrValue),
    .pending(pending), .ackValid(ackValid), .ackVector(ackVector),
    .priReq(priReq), .secReq(secReq), .priIsr(priIsr), .secIsr(secIsr)
  );

  int checks = 0, errors = 0;

  // reference model state
  logic [7:0] mPriReq = 0, mSecReq = 0, mPriIsr = 0, mSecIsr = 0;
  logic mPriFlag = 0, mSecFlag = 0, mAckValid = 0;
  logic [2:0] mPriPtr = 3'd7, mSecPtr = 3'd7;
  logic [15:0] mAckVector = 16'hFFFF;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int pickLine(input logic [7:0] elig, input logic [2:0] ptr);
    int pos;
    for (int k = 1; k <= 8; k++) begin
      pos = (int'(ptr) + k) % 8;
      if (elig[pos]) return pos;
    end
    return -1;
  endfunction

  function automatic logic expPending();
    return ((mPriReq & ~(priMask | 8'h04)) != 0) || ((mSecReq & ~secMask) != 0);
  endfunction

  task automatic modelStep();
    logic [7:0] pr, sr, pi, si;
    logic pf, sf;
    int w;
    pr = mPriReq; sr = mSecReq; pi = mPriIsr; si = mSecIsr; pf = mPriFlag; sf = mSecFlag;
    if (assertPulse) begin
      if (assertLine < 8) begin
        if (!priMask[assertLine[2:0]]) begin pr[assertLine[2:0]] = 1; pf = 1; end
      end else if (!secMask[assertLine[2:0]]) begin
        sr[assertLine[2:0]] = 1; sf = 1; pr[2] = 1; pf = 1;
      end
    end
    if (deassertPulse) begin
      if (deassertLine < 8) pr[deassertLine[2:0]] = 0;
      else begin
        sr[deassertLine[2:0]] = 0;
        if (sr == 0) pr[2] = 0;
      end
    end
    mAckValid = ackStrobe;
    mAckVector = 16'hFFFF;
    if (ackStrobe && (pf || sf)) begin
      w = pickLine(pr & ~priMask & 8'hFB, mPriPtr);
      if (w >= 0) begin
        pr[w] = 0; pi[w] = 1;
        if (pr == 0) pf = 0;
        mAckVector = 16'(w) + {8'h00, priVecBase};
      end else begin
        w = pickLine(sr & ~secMask, mSecPtr);
        if (w >= 0) begin
          sr[w] = 0; pr[2] = 0; si[w] = 1; pi[2] = 1;
          if (sr == 0) begin sf = 0; if (pr == 0) pf = 0; end
          mAckVector = 16'(w) + {8'h00, secVecBase};
        end
      end
    end
    if (ptrLoad) begin
      if (ptrSelSec) mSecPtr = ptrValue; else mPriPtr = ptrValue;
    end
    mPriReq = pr; mSecReq = sr; mPriIsr = pi; mSecIsr = si; mPriFlag = pf; mSecFlag = sf;
  endtask

  task automatic compareAll();
    chk("R2", "priReq", priReq, mPriReq);
    chk("R3", "secReq", secReq, mSecReq);
    chk("R4", "pending", pending, expPending());
    chk("R11", "priIsr", priIsr, mPriIsr);
    chk("R7", "secIsr", secIsr, mSecIsr);
    chk("R10", "ackValid", ackValid, mAckValid);
    if (mAckValid) chk("R6", "ackVector", ackVector, mAckVector);
  endtask

  // one clock: inputs already set at a falling edge
  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
    assertPulse = 0; deassertPulse = 0; ackStrobe = 0; ptrLoad = 0;
  endtask

  task automatic raise(input int line);
    assertPulse = 1; assertLine = 4'(line); tick();
  endtask

  task automatic drop(input int line);
    deassertPulse = 1; deassertLine = 4'(line); tick();
  endtask

  task automatic ack(input string req, input logic [15:0] exp);
    ackStrobe = 1; tick();
    chk(req, "directed vector", ackVector, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state
    chk("R1", "priReq after reset", priReq, 8'h00);
    chk("R1", "secIsr after reset", secIsr, 8'h00);
    chk("R1", "pending after reset", pending, 1'b0);
    chk("R1", "ackValid after reset", ackValid, 1'b0);
    // R9: acknowledge with no flag set
    ack("R9", 16'hFFFF);
    // R1 / R5: default pointer 7 puts line 0 first
    raise(7); raise(0);
    ack("R1", 16'h0020);
    ack("R5", 16'h0027);
    // R2: masked assert ignored
    priMask = 8'h10; raise(4);
    chk("R2", "masked assert", priReq, 8'h00);
    priMask = 8'h00;
    // R3: cascade bit follows the secondary register
    raise(9);
    chk("R3", "cascade set", priReq, 8'h04);
    chk("R4", "pending from secondary", pending, 1'b1);
    raise(12); drop(9);
    chk("R3", "cascade kept", priReq, 8'h04);
    drop(12);
    chk("R3", "cascade cleared", priReq, 8'h00);
    // R9: flags stale, nothing eligible
    ack("R9", 16'hFFFF);
    // R7: secondary grant pairs bookkeeping
    raise(11);
    ack("R7", 16'h0073);
    chk("R7", "cascade in service", priIsr[2], 1'b1);
    // R5: rotated primary pointer
    ptrLoad = 1; ptrSelSec = 0; ptrValue = 3'd3; tick();
    raise(1); raise(5);
    ack("R5", 16'h0025);
    // R6: vector sum does not wrap at 8 bits
    priVecBase = 8'hFC;
    ack("R6", 16'h00FD);
    raise(7);
    ack("R6", 16'h0103);
    priVecBase = 8'h20;
    // R10: assert and acknowledge in the same cycle
    assertPulse = 1; assertLine = 4'd6; ackStrobe = 1; tick();
    chk("R10", "same-cycle vector", ackVector, 16'h0026);
    // R6: primary before secondary, then R7 secondary
    raise(0); raise(10);
    ack("R6", 16'h0020);
    ack("R7", 16'h0072);
    // R4: masking an existing request hides it
    raise(3);
    priMask = 8'h08;
    #1 chk("R4", "masked pending", pending, 1'b0);
    ack("R9", 16'hFFFF);
    priMask = 8'h00;
    ack("R6", 16'h0023);
    // R8: random mixture against the model
    for (int i = 0; i < 3000; i++) begin
      assertPulse = ($urandom_range(0, 9) < 5);
      assertLine = 4'($urandom_range(0, 15));
      deassertPulse = ($urandom_range(0, 9) < 2);
      deassertLine = 4'($urandom_range(0, 15));
      ackStrobe = ($urandom_range(0, 9) < 3);
      ptrLoad = ($urandom_range(0, 19) == 0);
      ptrSelSec = 1'($urandom_range(0, 1));
      ptrValue = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 29) == 0) begin
        priMask = 8'($urandom & $urandom & $urandom);
        secMask = 8'($urandom & $urandom & $urandom);
      end
      if ($urandom_range(0, 99) == 0) begin
        priVecBase = 8'($urandom);
        secVecBase = 8'($urandom);
      end
      tick();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule